// File: doc/BRIEF.md
# Peripheral Clock Divider with Change Handshake

This block produces the clock for one peripheral domain from one of several source clocks. Software programs it through a single 32-bit control word. The word holds a two-bit source select, an integer divider, a stop bit and a change-enable bit. A read-only busy flag reports that a change is still in flight. Each source clock reaches the block as a tick input in the reference clock domain. A tick marks one edge of that source, so one source period gives two ticks. The output is a register in the reference domain that toggles after a programmed number of ticks of the selected source.

New divider and source values do not take effect when they are written. Software must write them with change-enable set. The block then raises busy and waits for a safe point, which is the end of a high phase of the output or any cycle in which the output is idle and low. At that point it moves to the new setting and clears busy and change-enable. Software polls busy until it reads 0. The stop bit acts at once, but the output always finishes its current high phase before it is held low. Each instance is fixed at build time by parameters: the divider width, a coefficient of 1 or 2, the base position of the three control bits, the four-entry source route table, and an optional active-low enable for an attached PHY clock.

Top module: `peripheral_clkdiv`

## Requirements
- R1: After reset the control word reads source select 00, stop 1, busy 0, change-enable 0 and divider 0. On an instance with a PHY enable, bit 26 reads 1. The output is low.
- R2: The select field (bits 31:30) indexes a per-instance four-entry route table. By default code 00 is "stop", 01 is source 0, 10 is source 1 and 11 is "invalid". A route to stop or invalid leaves the output low.
- R3: While the output runs, each high phase and each low phase lasts (divider + 1) × COEF ticks of the selected source, with COEF equal to 1 or 2.
- R4: Stop sits at bit BASE, busy at BASE+1 and change-enable at BASE+2. The divider occupies the low DIV_W bits. BASE is 27 on most instances and 26 on one.
- R5: A write with change-enable set makes busy read 1 in the cycle after the write.
- R6: A pending change is applied at the next falling edge of the output, or on the next clock if the output is idle and low. In the cycle that follows, busy and change-enable read 0 and the output is low.
- R7: A write with change-enable 0 updates the read-back fields. It leaves the running ratio and the running source unchanged.
- R8: With stop set, the output completes any high phase and is then held low. Clearing stop resumes the output at the applied ratio. The block is enabled exactly when the stop bit reads 0.
- R9: A new source select committed through change-enable switches the output to count ticks of the new source after the boundary.
- R10: On an instance with a PHY enable, bit 26 is active low. Writing 0 drives phyClkOn high and writing 1 drives it low.
- R11: The largest divider value gives phases of 2^DIV_W × COEF ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe for the control word |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Control word read-back with live busy |
| srcTick | input | NUM_SRC | One tick per source clock edge, one per source |
| clkOut | output | 1 | Divided output clock |
| phyClkOn | output | 1 | PHY clock enable (0 on instances without it) |

## Verification
The checker watches four properties on every cycle. Busy must follow a change-enable write. The applied source and divider must hold while busy is low. When busy drops by itself, the output and change-enable must be low. A stopped output that is low must stay low. Only the bench scenarios can show the exact phase lengths for each divider, coefficient and source. They also show that a select change really moves the output to another tick stream, that invalid and stop routes silence the output, and that the PHY enable and the 26-based bit layout read back correctly.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int SEL_W   = 2;
  localparam int ROUTE_W = 3;

  // route codes 0..3 name a source; 4 = stop, 5 = invalid
  localparam logic [ROUTE_W-1:0] ROUTE_STOP    = 3'd4;
  localparam logic [ROUTE_W-1:0] ROUTE_INVALID = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic run;       // counting allowed (not stopped, valid source)
    logic srcValid;  // applied route names a real source
  } dpCtrl_t;

  // datapath -> control strobes
  typedef struct packed {
    logic edgeOk;    // safe point to switch settings this cycle
    logic level;     // current output level
  } dpStat_t;

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int CTL_BASE   = 27,
  parameter int HAS_PHY_EN = 0,
  parameter int NUM_SRC    = 4,
  parameter logic [4*ROUTE_W-1:0] ROUTE = {ROUTE_INVALID, 3'd1, 3'd0, ROUTE_STOP}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  dpStat_t          stat,
  output dpCtrl_t          ctl,
  output logic [SEL_W-1:0] srcIdx,
  output logic [SEL_W-1:0] actSel,
  output logic [DIV_W-1:0] actDiv,
  output logic             phyClkOn
);

  localparam int STOP_BIT = CTL_BASE;
  localparam int BUSY_BIT = CTL_BASE + 1;
  localparam int CE_BIT   = CTL_BASE + 2;
  localparam int PHY_BIT  = 26;

  localparam logic [31:0] DIV_MASK = (32'h1 << DIV_W) - 32'h1;
  localparam logic [31:0] PHY_MASK = (HAS_PHY_EN != 0) ? (32'h1 << PHY_BIT) : 32'h0;
  localparam logic [31:0] WR_MASK  = (32'h3 << 30) | (32'h1 << STOP_BIT) |
                                     (32'h1 << CE_BIT) | DIV_MASK | PHY_MASK;
  localparam logic [31:0] RST_VAL  = (32'h1 << STOP_BIT) | PHY_MASK;

  logic [31:0]        regQ;
  logic               busyQ;
  logic [SEL_W-1:0]   actSelQ;
  logic [DIV_W-1:0]   actDivQ;
  logic               apply;
  logic [ROUTE_W-1:0] routeCode;

  assign apply = busyQ && stat.edgeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ  <= RST_VAL;
      busyQ <= 1'b0;
    end else if (wrEn) begin
      regQ  <= wrData & WR_MASK;
      busyQ <= wrData[CE_BIT];
    end else if (apply) begin
      regQ[CE_BIT] <= 1'b0;
      busyQ        <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSelQ <= '0;
      actDivQ <= '0;
    end else if (apply) begin
      actSelQ <= regQ[31:30];
      actDivQ <= regQ[DIV_W-1:0];
    end
  end

  always_comb begin
    routeCode    = ROUTE[actSelQ*ROUTE_W +: ROUTE_W];
    ctl.srcValid = (32'(routeCode) < NUM_SRC);
    ctl.run      = ctl.srcValid && !regQ[STOP_BIT];
    srcIdx       = routeCode[SEL_W-1:0];
  end

  always_comb begin
    rdData           = regQ;
    rdData[BUSY_BIT] = busyQ;
  end

  assign actSel   = actSelQ;
  assign actDiv   = actDivQ;
  assign phyClkOn = (HAS_PHY_EN != 0) && !regQ[PHY_BIT];

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int COEF    = 1,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  dpCtrl_t            ctl,
  input  logic [SEL_W-1:0]   srcIdx,
  input  logic [DIV_W-1:0]   actDiv,
  output dpStat_t            stat,
  output logic               clkOut
);

  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cntQ;
  logic             outQ;
  logic [3:0]       tickPad;
  logic [CNT_W-1:0] phaseLen;
  logic [CNT_W-1:0] halfLast;
  logic             tickSel;
  logic             frozen;
  logic             wrap;

  assign tickPad  = 4'(srcTick);
  assign phaseLen = ({2'b00, actDiv} + CNT_W'(1)) * CNT_W'(COEF);
  assign halfLast = phaseLen - CNT_W'(1);
  assign tickSel  = ctl.srcValid && tickPad[srcIdx];
  assign frozen   = !ctl.run && !outQ;
  assign wrap     = tickSel && (cntQ == halfLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      outQ <= 1'b0;
    end else if (frozen) begin
      cntQ <= '0;
    end else if (tickSel) begin
      if (wrap) begin
        cntQ <= '0;
        outQ <= ~outQ;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assign stat.edgeOk = frozen || (wrap && outQ);
  assign stat.level  = outQ;
  assign clkOut      = outQ;

endmodule

// File: rtl/peripheral_clkdiv.sv
module peripheral_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int COEF       = 1,
  parameter int CTL_BASE   = 27,
  parameter int HAS_PHY_EN = 0,
  parameter int NUM_SRC    = 4,
  parameter logic [4*ROUTE_W-1:0] ROUTE = {ROUTE_INVALID, 3'd1, 3'd0, ROUTE_STOP}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic               clkOut,
  output logic               phyClkOn
);

  dpCtrl_t          ctl;
  dpStat_t          stat;
  logic [SEL_W-1:0] srcIdx;
  logic [SEL_W-1:0] actSel;
  logic [DIV_W-1:0] actDiv;

  clkdiv_ctrl #(
    .DIV_W(DIV_W), .CTL_BASE(CTL_BASE), .HAS_PHY_EN(HAS_PHY_EN),
    .NUM_SRC(NUM_SRC), .ROUTE(ROUTE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .stat(stat), .ctl(ctl), .srcIdx(srcIdx), .actSel(actSel),
    .actDiv(actDiv), .phyClkOn(phyClkOn)
  );

  clkdiv_datapath #(
    .DIV_W(DIV_W), .COEF(COEF), .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .ctl(ctl), .srcIdx(srcIdx),
    .actDiv(actDiv), .stat(stat), .clkOut(clkOut)
  );

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int DIV_W    = 8,
  parameter int CTL_BASE = 27
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic             clkOut,
  input logic [1:0]       actSel,
  input logic [DIV_W-1:0] actDiv
);

  localparam int STOP_BIT = CTL_BASE;
  localparam int BUSY_BIT = CTL_BASE + 1;
  localparam int CE_BIT   = CTL_BASE + 2;

  // R5: change-enable write raises busy next cycle
  a_r5_busy_after_ce: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[CE_BIT]) |=> rdData[BUSY_BIT]);

  // R7: without a pending change the applied settings never move
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[BUSY_BIT] |=> ($stable(actDiv) && $stable(actSel)));

  // R6: a change completes only with the output low and change-enable cleared
  a_r6_apply_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdData[BUSY_BIT]) && !$past(wrEn)) |-> (!clkOut && !rdData[CE_BIT]));

  // R8: a stopped, low output stays low
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[STOP_BIT] && !clkOut) |=> !clkOut);

endmodule

bind peripheral_clkdiv clkdiv_chk #(.DIV_W(DIV_W), .CTL_BASE(CTL_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .clkOut(clkOut), .actSel(actSel), .actDiv(actDiv)
);

// File: tb/peripheral_clkdiv_tb_top.sv
`timescale 1ns/1ps
module peripheral_clkdiv_tb_top;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrEnB = 1'b0;
  logic [31:0] wrData = '0, wrDataB = '0;
  logic [31:0] rdData, rdDataB;
  logic [3:0]  ticks = 4'b0000;
  logic        clkOut, clkOutB, phyClkOn, phyClkOnB;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  // instance A: 4-bit divider, coefficient 2, base 27, PHY enable
  peripheral_clkdiv #(.DIV_W(4), .COEF(2), .CTL_BASE(27), .HAS_PHY_EN(1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .srcTick(ticks), .clkOut(clkOut), .phyClkOn(phyClkOn));

  // instance B: 8-bit divider, coefficient 1, base 26
  peripheral_clkdiv #(.DIV_W(8), .COEF(1), .CTL_BASE(26), .HAS_PHY_EN(0)) dut_b (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .wrData(wrDataB), .rdData(rdDataB),
    .srcTick(ticks), .clkOut(clkOutB), .phyClkOn(phyClkOnB));

  // source 0 ticks every cycle, source 1 every third cycle
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ticks[0] = rstN;
      ph = (ph + 1) % 3;
      ticks[1] = rstN && (ph == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // control word for instance A (stop 27, busy 28, change-enable 29, PHY 26)
  function automatic logic [31:0] mk(int sel, int stop, int ce, int phyOff, int dv);
    return (32'(sel) << 30) | (32'(ce) << 29) | (32'(stop) << 27) |
           (32'(phyOff) << 26) | (32'(dv) & 32'hF);
  endfunction

  task automatic wrA(input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic wrB(input logic [31:0] d);
    @(negedge clk); wrEnB = 1'b1; wrDataB = d;
    @(negedge clk); wrEnB = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (rdData[28] && n < 200) begin @(negedge clk); n++; end
    chk(!rdData[28] && !rdData[29] && !clkOut, tag, {rdData[31:1], clkOut}, {rdData[31:30], 2'b00, rdData[27:1], 1'b0});
  endtask

  task automatic expect_phase(input int hi, input int lo, input string tag);
    expItem_t e;
    e.hi = hi; e.lo = lo; e.tag = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  task automatic checkLow(input int n, input string tag);
    int highs = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (clkOut) highs++; end
    chk(highs == 0, tag, 32'(highs), 32'd0);
  endtask

  // scoreboard monitor for instance A
  initial begin
    forever begin
      int hi, lo;
      expItem_t e;
      wait (expQ.size() > 0);
      e = expQ[0];
      do @(negedge clk); while (clkOut !== 1'b0);
      do @(negedge clk); while (clkOut !== 1'b1);
      hi = 0; lo = 0;
      while (clkOut === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
      while (clkOut === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
      chk(hi == e.hi && lo == e.lo, e.tag, {hi[15:0], lo[15:0]}, {e.hi[15:0], e.lo[15:0]});
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog (R1..R11 run) actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hiB, loB;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state on both instances
    chk(rdData == 32'h0C00_0000, "R1 reset word A", rdData, 32'h0C00_0000);
    chk(rdDataB == 32'h0400_0000, "R1 reset word B", rdDataB, 32'h0400_0000);
    chk(!clkOut && !clkOutB && !phyClkOn, "R1 outputs low", {29'd0, clkOut, clkOutB, phyClkOn}, 32'd0);
    checkLow(20, "R2 stop route silent after reset");

    // R5/R6: commit from idle: busy for exactly one cycle
    wrA(mk(1, 0, 1, 1, 3));
    chk(rdData[28] && rdData[29], "R5 busy after change-enable", rdData, rdData | 32'h3000_0000);
    @(negedge clk);
    chk(!rdData[28] && !rdData[29], "R6 idle apply clears busy", rdData, rdData & ~32'h3000_0000);
    chk(rdData[27] == 1'b0, "R8 enabled reads stop clear", rdData, rdData & ~32'h0800_0000);

    // R3: div 3, coef 2 -> 8 ticks per phase
    expect_phase(8, 8, "R3 ratio div3");

    // R7: divider and select written without change-enable: no effect
    wrA(mk(2, 0, 0, 1, 15));
    chk(rdData[3:0] == 4'hF && rdData[31:30] == 2'b10 && !rdData[28], "R7 fields read back", rdData, mk(2, 0, 0, 1, 15));
    expect_phase(8, 8, "R7 ratio unchanged");

    // R6: commit while running waits for a falling boundary
    wrA(mk(1, 0, 1, 1, 1));
    chk(rdData[28], "R5 busy while running", rdData, rdData | 32'h1000_0000);
    waitIdle("R6 apply at falling edge");
    expect_phase(4, 4, "R3 ratio div1");

    // R8: stop finishes high phase, then holds low; clear resumes
    wrA(mk(1, 1, 0, 1, 1));
    chk(rdData[27], "R8 stop reads back", rdData, rdData | 32'h0800_0000);
    repeat (10) @(negedge clk);
    checkLow(30, "R8 held low while stopped");
    wrA(mk(1, 0, 0, 1, 1));
    expect_phase(4, 4, "R8 resume ratio");

    // R11: largest divider -> 16*2 = 32
    wrA(mk(1, 0, 1, 1, 15));
    waitIdle("R6 apply for max divider");
    expect_phase(32, 32, "R11 max divider");

    // R9: switch to source 1 (tick every 3 cycles), div 0 -> 2 ticks = 6 cycles
    wrA(mk(2, 0, 1, 1, 0));
    waitIdle("R9 switch apply");
    expect_phase(6, 6, "R9 new source ratio");

    // R2: invalid route silences the output
    wrA(mk(3, 0, 1, 1, 0));
    waitIdle("R2 invalid apply");
    checkLow(40, "R2 invalid route silent");

    // R10: PHY enable active low at bit 26
    wrA(mk(3, 0, 0, 0, 0));
    chk(phyClkOn && !rdData[26], "R10 phy on when bit clear", {31'd0, phyClkOn}, 32'd1);
    wrA(mk(3, 0, 0, 1, 0));
    chk(!phyClkOn && rdData[26], "R10 phy off when bit set", {31'd0, phyClkOn}, 32'd0);

    // R4: base-26 layout (stop 26, busy 27, change-enable 28), coef 1
    wrB((32'd1 << 30) | (32'd1 << 28) | 32'd4);
    chk(rdDataB[27] && rdDataB[28] && !rdDataB[26], "R4 busy at base+1 on B", rdDataB, (32'd1 << 30) | (32'h3 << 27) | 32'd4);
    @(negedge clk);
    chk(!rdDataB[27], "R4 busy clears on B", rdDataB, rdDataB & ~32'h0800_0000);
    do @(negedge clk); while (clkOutB !== 1'b1);
    hiB = 0; loB = 0;
    while (clkOutB === 1'b1 && hiB < 1000) begin hiB++; @(negedge clk); end
    while (clkOutB === 1'b0 && loB < 1000) begin loB++; @(negedge clk); end
    chk(hiB == 5 && loB == 5, "R3 coef1 ratio on B", {hiB[15:0], loB[15:0]}, {16'd5, 16'd5});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule